// File: doc/BRIEF.md
# Serial Transmitter with Break and Sync Header Support

This block is the transmit half of an asynchronous serial port. It can also open a master-style frame header on a single-wire bus. Bytes go out as 8N1 frames, least significant bit first. Each bit lasts a fixed number of ticks from an external oversampling baud strobe. Two registers queue outgoing characters: a one-byte holding register and the shift register behind it. A flag tells the writer when the holding register can take another byte.

To send a header, software first pulses the break request. It then writes a dummy byte and follows it with the sync byte, normally 0x55. The dummy write is tagged as a break: its value is thrown away and the line is instead held low for thirteen bit-times, then released for one stop bit. Hardware drops the break request once that stop bit has finished. The sync byte, queued behind the break, follows as an ordinary frame with no idle gap.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset, `txLine` is 1, `holdEmpty` is 1, and `txBusy`, `sendBreak` and `overflow` are 0.
- R2: A normal character is sent as a 0 start bit, then 8 data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 `baudTick` pulses.
- R3: A write accepted while `sendBreak` is 1 and no break is already queued or shifting produces a break character. A break is 13 consecutive low bit-times (the start bit plus 12 more) followed by one high stop bit. The written value never appears on the line.
- R4: A pulse on `setBreak` sets `sendBreak`. It stays set while the break is queued and shifting, and clears by itself when the break's stop bit completes.
- R5: A byte written after the break's dummy byte is sent as a normal frame. Its start bit begins as the break's stop bit ends, with no idle time between them.
- R6: `holdEmpty` is 1 exactly when the holding register can accept a byte. It reads 0 in the cycle after an accepted write, and returns to 1 once the byte has moved into the shift register.
- R7: The holding and shift registers form a two-character queue. A write made while `holdEmpty` is 0 is dropped and never transmitted, and it sets `overflow`. `overflow` stays at 1 until reset.
- R8: `txBusy` is 1 from the start bit of a character until the stop bit of the last queued character completes. It stays 1 across back-to-back characters. While `txBusy` is 0, `txLine` is 1.
- R9: While `txEnable` is 0, no new character starts. A queued byte waits in the holding register and goes out once `txEnable` returns to 1.
- R10: A `setBreak` pulse that arrives while a normal character is shifting leaves that character intact. The break is applied to the next character written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Oversampling strobe; 16 pulses make one bit-time |
| txEnable | input | 1 | Allows a queued character to begin transmission |
| setBreak | input | 1 | One-cycle pulse that requests a break for the next written character |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to transmit; ignored when the write becomes a break |
| txLine | output | 1 | Serial output; idles high |
| holdEmpty | output | 1 | Holding register can accept a byte |
| txBusy | output | 1 | A character is on the line |
| sendBreak | output | 1 | Break request pending; cleared by hardware |
| overflow | output | 1 | Sticky flag set by a write that was dropped |

## Verification
Some properties are checked on every cycle:
- the line is never low while the block reports itself idle;
- a dropped write always raises the sticky overflow flag, and the flag never falls;
- a queued byte is never lost while transmission is disabled;
- the break request clears in the cycle after a break's stop bit ends.

Some behaviour only the bench scenarios can show:
- the exact bit patterns and durations on the line;
- the thirteen-bit low period and the discarded dummy value;
- the back-to-back timing of the sync byte;
- the deferral of a break requested in the middle of a frame.

The bench shows these by decoding the serial line and comparing the decoded characters against a queue of expected characters.

// File: rtl/brk_uart_tx_pkg.sv
package brk_uart_tx_pkg;

  // Strobes from the control unit to the datapath, valid for one cycle.
  typedef struct packed {
    logic captureHold; // latch wrData into the holding register
    logic loadFrame;   // move the holding register into the shifter
    logic loadBreak;   // when loading, build a break pattern instead of data
    logic shiftBit;    // advance the shifter by one bit
  } txStrobe_t;

endpackage

// File: rtl/brk_uart_tx_ctrl.sv
module brk_uart_tx_ctrl
  import brk_uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  parameter int BREAK_LOW  = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      txEnable,
  input  logic      setBreak,
  input  logic      wrValid,
  output txStrobe_t strobe,
  output logic      holdEmpty,
  output logic      txBusy,
  output logic      sendBreak,
  output logic      overflow
);

  localparam int NORM_BITS = DATA_W + 2;
  localparam int BRK_BITS  = BREAK_LOW + 1;
  localparam int TICK_W    = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int MAX_BITS  = (BRK_BITS > NORM_BITS) ? BRK_BITS : NORM_BITS;
  localparam int BIT_W     = $clog2(MAX_BITS + 1);

  logic              holdValid;
  logic              holdIsBreak;
  logic              breakClaimed;
  logic              active;
  logic              curIsBreak;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitsLeft;

  logic tickEnd, lastBit, frameEnd, canLoad, wrAccept, wrDrop, tagBreak, breakDone;

  assign tickEnd   = active && baudTick && (tickCnt == TICK_W'(OVERSAMPLE - 1));
  assign lastBit   = (bitsLeft == BIT_W'(1));
  assign frameEnd  = tickEnd && lastBit;
  assign canLoad   = txEnable && holdValid && (!active || frameEnd);
  assign wrAccept  = wrValid && !holdValid;
  assign wrDrop    = wrValid && holdValid;
  assign tagBreak  = sendBreak && !breakClaimed;
  assign breakDone = frameEnd && curIsBreak;

  always_comb begin
    strobe.captureHold = wrAccept;
    strobe.loadFrame   = canLoad;
    strobe.loadBreak   = holdIsBreak;
    strobe.shiftBit    = tickEnd && !lastBit;
  end

  // Holding register bookkeeping and break tagging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid    <= 1'b0;
      holdIsBreak  <= 1'b0;
      breakClaimed <= 1'b0;
      sendBreak    <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      if (wrAccept) begin
        holdValid   <= 1'b1;
        holdIsBreak <= tagBreak;
      end else if (canLoad) begin
        holdValid   <= 1'b0;
      end
      if (wrAccept && tagBreak)
        breakClaimed <= 1'b1;
      else if (breakDone)
        breakClaimed <= 1'b0;
      if (setBreak)
        sendBreak <= 1'b1;
      else if (breakDone)
        sendBreak <= 1'b0;
      if (wrDrop)
        overflow <= 1'b1;
    end
  end

  // Bit timing of the shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      curIsBreak <= 1'b0;
      tickCnt    <= '0;
      bitsLeft   <= '0;
    end else if (canLoad) begin
      active     <= 1'b1;
      curIsBreak <= holdIsBreak;
      tickCnt    <= '0;
      bitsLeft   <= holdIsBreak ? BIT_W'(BRK_BITS) : BIT_W'(NORM_BITS);
    end else if (frameEnd) begin
      active     <= 1'b0;
      curIsBreak <= 1'b0;
      bitsLeft   <= '0;
    end else if (tickEnd) begin
      tickCnt  <= '0;
      bitsLeft <= bitsLeft - BIT_W'(1);
    end else if (active && baudTick) begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  assign holdEmpty = !holdValid;
  assign txBusy    = active;

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !holdEmpty |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R7
  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    !holdEmpty && !txEnable |=> !holdEmpty); // R9
  AST_BREAK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    breakDone && !setBreak |=> !sendBreak); // R4
  AST_SET_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    setBreak |=> sendBreak); // R4
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> (bitsLeft != '0) && (bitsLeft <= BIT_W'(MAX_BITS))); // R2

endmodule

// File: rtl/brk_uart_tx_dp.sv
module brk_uart_tx_dp
  import brk_uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BREAK_LOW = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine
);

  localparam int NORM_BITS = DATA_W + 2;
  localparam int BRK_BITS  = BREAK_LOW + 1;
  localparam int FRAME_W   = (BRK_BITS > NORM_BITS) ? BRK_BITS : NORM_BITS;

  logic [DATA_W-1:0]  holdData;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] normPattern;
  logic [FRAME_W-1:0] brkPattern;

  // Frame images, bit 0 leaves first; upper bits are idle-high fill.
  generate
    if (FRAME_W > NORM_BITS) begin : g_padNorm
      assign normPattern = {{(FRAME_W - NORM_BITS){1'b1}}, 1'b1, holdData, 1'b0};
    end else begin : g_exactNorm
      assign normPattern = {1'b1, holdData, 1'b0};
    end
    if (FRAME_W > BRK_BITS) begin : g_padBrk
      assign brkPattern = {{(FRAME_W - BRK_BITS){1'b1}}, 1'b1, {BREAK_LOW{1'b0}}};
    end else begin : g_exactBrk
      assign brkPattern = {1'b1, {BREAK_LOW{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      holdData <= '0;
    else if (strobe.captureHold)
      holdData <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftReg <= '1;
    else if (strobe.loadFrame)
      shiftReg <= strobe.loadBreak ? brkPattern : normPattern;
    else if (strobe.shiftBit)
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
  end

  assign txLine = shiftReg[0];

  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFrame |=> !txLine); // R2

endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
  import brk_uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8,
  parameter int BREAK_LOW  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              txEnable,
  input  logic              setBreak,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txBusy,
  output logic              sendBreak,
  output logic              overflow
);

  txStrobe_t strobe;

  brk_uart_tx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_W    (DATA_W),
    .BREAK_LOW (BREAK_LOW)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .txEnable (txEnable),
    .setBreak (setBreak),
    .wrValid  (wrValid),
    .strobe   (strobe),
    .holdEmpty(holdEmpty),
    .txBusy   (txBusy),
    .sendBreak(sendBreak),
    .overflow (overflow)
  );

  brk_uart_tx_dp #(
    .DATA_W   (DATA_W),
    .BREAK_LOW(BREAK_LOW)
  ) dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .txLine(txLine)
  );

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine); // R8
  AST_LOW_IS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !txLine |-> txBusy); // R8

endmodule

// File: tb/brk_uart_tx_test.sv
`timescale 1ns/1ps
module brk_uart_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CYC    = 16 * TICK_DIV;
  localparam int BRK_CODE   = 256 + 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic txEnable = 1'b0;
  logic setBreak = 1'b0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic txLine, holdEmpty, txBusy, sendBreak, overflow;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int obsQ[$];
  int obsStart[$];
  int expQ[$];

  brk_uart_tx uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txEnable(txEnable),
    .setBreak(setBreak), .wrValid(wrValid), .wrData(wrData),
    .txLine(txLine), .holdEmpty(holdEmpty), .txBusy(txBusy),
    .sendBreak(sendBreak), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Baud strobe generator and cycle counter
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      baudTick = ((cyc % TICK_DIV) == 0);
    end
  end

  // Line decoder: normal frames give the data value, breaks 256 + low bit-times
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && !txLine) begin
        logic [7:0] d;
        int lows;
        int st;
        st = cyc;
        check(txBusy == 1'b1, "R8 busy at start bit", txBusy, 1);
        repeat (BIT_CYC/2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          repeat (BIT_CYC) @(negedge clk);
          d[k] = txLine;
        end
        repeat (BIT_CYC) @(negedge clk);
        if (txLine) begin
          obsQ.push_back(int'(d));
        end else begin
          lows = 10;
          for (int k = 0; k < 40; k++) begin
            repeat (BIT_CYC) @(negedge clk);
            if (txLine) break;
            lows++;
          end
          obsQ.push_back(256 + lows);
        end
        obsStart.push_back(st);
      end
    end
  end

  task automatic putByte(input logic [7:0] v);
    while (!holdEmpty) @(negedge clk);
    wrValid = 1'b1;
    wrData = v;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseBreak();
    setBreak = 1'b1;
    @(negedge clk);
    setBreak = 1'b0;
  endtask

  task automatic drain();
    while (txBusy || !holdEmpty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic string frameReq(input int code);
    return (code >= 256) ? "R3 break frame" : "R2 data frame";
  endfunction

  task automatic compareFrames();
    check(obsQ.size() == expQ.size(), "R2 frame count", obsQ.size(), expQ.size());
    while (expQ.size() > 0 && obsQ.size() > 0) begin
      int e, o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      check(o == e, frameReq(e), o, e);
    end
    expQ.delete();
    obsQ.delete();
    obsStart.delete();
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1977);

    // R1 reset state
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R1 line", txLine, 1);
    check(holdEmpty == 1'b1, "R1 holdEmpty", holdEmpty, 1);
    check(txBusy == 1'b0, "R1 busy", txBusy, 0);
    check(sendBreak == 1'b0, "R1 sendBreak", sendBreak, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    rstN = 1'b1;
    txEnable = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R6 a single byte
    putByte(8'hA5);
    check(holdEmpty == 1'b0, "R6 holdEmpty after write", holdEmpty, 0);
    @(negedge clk);
    check(holdEmpty == 1'b1, "R6 holdEmpty after load", holdEmpty, 1);
    expQ.push_back(8'hA5);
    drain();
    check(txBusy == 1'b0 && txLine == 1'b1, "R8 idle after frame", txLine, 1);
    compareFrames();

    // R3/R4/R5 break header followed by sync
    pulseBreak();
    check(sendBreak == 1'b1, "R4 sendBreak set", sendBreak, 1);
    putByte(8'hC3);
    putByte(8'h55);
    check(sendBreak == 1'b1, "R4 sendBreak held during break", sendBreak, 1);
    expQ.push_back(BRK_CODE);
    expQ.push_back(8'h55);
    drain();
    check(sendBreak == 1'b0, "R4 sendBreak cleared", sendBreak, 0);
    if (obsStart.size() == 2) begin
      int gap;
      gap = obsStart[1] - obsStart[0];
      check(gap >= 14*BIT_CYC - TICK_DIV && gap <= 14*BIT_CYC + TICK_DIV,
            "R5 sync follows break back to back", gap, 14*BIT_CYC);
    end else begin
      check(1'b0, "R5 two frames seen", obsStart.size(), 2);
    end
    compareFrames();

    // R7 overflow: third write while both stages are full is dropped
    putByte(8'h11);
    putByte(8'h22);
    check(holdEmpty == 1'b0, "R7 queue full", holdEmpty, 0);
    wrValid = 1'b1; wrData = 8'h33;
    @(negedge clk);
    wrValid = 1'b0;
    check(overflow == 1'b1, "R7 overflow set", overflow, 1);
    expQ.push_back(8'h11);
    expQ.push_back(8'h22);
    drain();
    check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    compareFrames();

    // R9 transmission held off while disabled
    txEnable = 1'b0;
    putByte(8'h6E);
    repeat (12 * BIT_CYC) @(negedge clk);
    check(obsQ.size() == 0, "R9 nothing sent while disabled", obsQ.size(), 0);
    check(holdEmpty == 1'b0 && txLine == 1'b1, "R9 byte waits", holdEmpty, 0);
    txEnable = 1'b1;
    expQ.push_back(8'h6E);
    drain();
    compareFrames();

    // R10 break requested mid-frame applies to the next character
    putByte(8'h3C);
    repeat (4 * BIT_CYC) @(negedge clk);
    pulseBreak();
    putByte(8'h99);
    putByte(8'h55);
    expQ.push_back(8'h3C);
    expQ.push_back(BRK_CODE);
    expQ.push_back(8'h55);
    drain();
    check(sendBreak == 1'b0, "R10 sendBreak cleared after deferred break", sendBreak, 0);
    compareFrames();

    // Random traffic with occasional headers
    for (int i = 0; i < 30; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (($urandom % 5) == 0) begin
        drain();
        pulseBreak();
        putByte(8'($urandom));
        expQ.push_back(BRK_CODE);
      end
      putByte(b);
      expQ.push_back(int'(b));
    end
    drain();
    compareFrames();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule